// File: doc/BRIEF.md
# Layer Completion Handshake Coordinator

This block sequences evaluation through a layered network of binary neurons without a fixed timing budget per layer. Each neuron drives two outputs, an excitatory one and an inhibitory one, both low while the neuron is precharged. The neuron has finished evaluating once either output goes high. The coordinator watches these output pairs, works out when every neuron in a layer has finished, and only then lets the next layer evaluate.

A new-input strobe starts a round. The coordinator raises a global precharge for a set number of cycles and clears all completion state. It then enables the first layer. Each later layer is enabled once the layer before it is complete. When the last layer completes, a network-done flag rises and stays high until the next strobe. A strobe during a round abandons that round and starts again from precharge. The handshake is modelled as synchronous RTL so that it can be checked cycle by cycle.

The controller is a four-state machine. The states are HS_IDLE (after reset, nothing enabled), HS_PRECHARGE (global precharge held), HS_EVALUATE (layers enabled in turn) and HS_FINISHED (network done). The transitions are:

- IDLE→PRECHARGE, EVALUATE→PRECHARGE, FINISHED→PRECHARGE and PRECHARGE→PRECHARGE (counter restarted), all on a strobe.
- PRECHARGE→EVALUATE when the precharge count expires.
- EVALUATE→FINISHED when the last layer's done flag is set.

Top module: `layer_handshake`

## Requirements
- R1: After reset, precharge, every evaluate enable, every layer done flag and network-done are 0.
- R2: A new-input strobe makes precharge 1 from the next cycle for exactly PRECHARGE_CYCLES cycles. No evaluate enable is 1 while precharge is 1, and every done flag reads 0 during precharge.
- R3: A neuron is complete when its excitatory OR its inhibitory output is 1. Neuron j of layer k uses bit k*NEURONS_PER_LAYER+j of each output vector. The done flag of an enabled layer becomes 1 one cycle after all of its neurons are complete in the same cycle.
- R4: Evaluate enable of layer 0 is 1 from the first cycle after precharge ends. Evaluate enable of layer k>0 is 1 only while the done flag of layer k-1 is 1.
- R5: Neuron completions seen during precharge, in idle, or for a layer whose evaluate enable is 0 do not set any done flag.
- R6: A layer done flag, once set, stays 1 until the next new-input strobe, even if the neuron outputs fall.
- R7: Network-done becomes 1 one cycle after the last layer's done flag is set and stays 1, with all enables held, until the next new-input strobe.
- R8: A strobe during evaluation, or while network-done is set, aborts the round: precharge restarts and all flags clear. A strobe during precharge restarts the precharge count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| new_input | input | 1 | One-cycle strobe that a new input vector is present |
| ex_out | input | NUM_LAYERS*NEURONS_PER_LAYER | Excitatory outputs of all neurons, layer-major |
| inh_out | input | NUM_LAYERS*NEURONS_PER_LAYER | Inhibitory outputs of all neurons, layer-major |
| precharge | output | 1 | Global precharge to every neuron |
| eval_en | output | NUM_LAYERS | Evaluate enable per layer |
| layer_done | output | NUM_LAYERS | Completion flag per layer |
| net_done | output | 1 | Final layer complete for the current input |

## Verification
Several behaviours are checked by assertions on every cycle. No enable is active under precharge. Done flags only ever set in layer order. A flag only rises after its layer was fully complete. Flags and network-done persist until a strobe, and a strobe always lands in precharge with cleared flags. Other behaviours can only be shown by the bench's scenarios against its cycle model. These are the exact precharge length, the one-cycle latencies from completion to done and from last done to network-done, the way completions arriving early or during precharge are ignored, and restarts that land mid-precharge or mid-round.

// File: rtl/layer_handshake_pkg.sv
package layer_handshake_pkg;
    typedef enum logic [1:0] {
        HS_IDLE      = 2'd0,
        HS_PRECHARGE = 2'd1,
        HS_EVALUATE  = 2'd2,
        HS_FINISHED  = 2'd3
    } hs_state_e;
endpackage

// File: rtl/completion_detect.sv
module completion_detect #(
    parameter int NUM_LAYERS        = 3,
    parameter int NEURONS_PER_LAYER = 4
) (
    input  logic [NUM_LAYERS*NEURONS_PER_LAYER-1:0] ex_out,
    input  logic [NUM_LAYERS*NEURONS_PER_LAYER-1:0] inh_out,
    output logic [NUM_LAYERS-1:0]                   layer_complete
);
    localparam int TOTAL = NUM_LAYERS * NEURONS_PER_LAYER;

    logic [TOTAL-1:0] neuron_fin;

    // Dual-rail style: either rail high marks the neuron as settled.
    assign neuron_fin = ex_out | inh_out;

    for (genvar k = 0; k < NUM_LAYERS; k++) begin : g_layer
        assign layer_complete[k] =
            &neuron_fin[k*NEURONS_PER_LAYER +: NEURONS_PER_LAYER];
    end
endmodule

// File: rtl/done_tracker.sv
module done_tracker #(
    parameter int NUM_LAYERS = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  evaluating,
    input  logic [NUM_LAYERS-1:0] eval_en,
    input  logic [NUM_LAYERS-1:0] layer_complete,
    output logic [NUM_LAYERS-1:0] layer_done
);
    for (genvar k = 0; k < NUM_LAYERS; k++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                layer_done[k] <= 1'b0;
            end else if (clear) begin
                layer_done[k] <= 1'b0;
            end else if (evaluating && eval_en[k] && layer_complete[k]) begin
                layer_done[k] <= 1'b1;
            end
        end

        // R3: a flag only rises after its layer was seen fully complete
        a_r3_rise_needs_complete : assert property (@(posedge clk) disable iff (!rst_n)
            $rose(layer_done[k]) |-> $past(layer_complete[k]));

        // R6: flag persists until a clear
        a_r6_done_sticky : assert property (@(posedge clk) disable iff (!rst_n)
            (layer_done[k] && !clear) |=> layer_done[k]);

        if (k > 0) begin : g_order
            // R4: done flags appear in layer order
            a_r4_done_order : assert property (@(posedge clk) disable iff (!rst_n)
                layer_done[k] |-> layer_done[k-1]);
        end
    end
endmodule

// File: rtl/layer_handshake.sv
module layer_handshake
    import layer_handshake_pkg::*;
#(
    parameter int NUM_LAYERS        = 3,
    parameter int NEURONS_PER_LAYER = 4,
    parameter int PRECHARGE_CYCLES  = 2
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    new_input,
    input  logic [NUM_LAYERS*NEURONS_PER_LAYER-1:0] ex_out,
    input  logic [NUM_LAYERS*NEURONS_PER_LAYER-1:0] inh_out,
    output logic                                    precharge,
    output logic [NUM_LAYERS-1:0]                   eval_en,
    output logic [NUM_LAYERS-1:0]                   layer_done,
    output logic                                    net_done
);
    localparam int CNT_W    = (PRECHARGE_CYCLES > 1) ? $clog2(PRECHARGE_CYCLES) : 1;
    localparam int CNT_LAST = PRECHARGE_CYCLES - 1;

    hs_state_e              state_q, state_d;
    logic [CNT_W-1:0]       cnt_q, cnt_d;
    logic [NUM_LAYERS-1:0]  layer_complete;
    logic                   evaluating;

    completion_detect #(
        .NUM_LAYERS        (NUM_LAYERS),
        .NEURONS_PER_LAYER (NEURONS_PER_LAYER)
    ) u_detect (
        .ex_out         (ex_out),
        .inh_out        (inh_out),
        .layer_complete (layer_complete)
    );

    done_tracker #(
        .NUM_LAYERS (NUM_LAYERS)
    ) u_track (
        .clk            (clk),
        .rst_n          (rst_n),
        .clear          (new_input),
        .evaluating     (evaluating),
        .eval_en        (eval_en),
        .layer_complete (layer_complete),
        .layer_done     (layer_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (new_input) begin
            state_d = HS_PRECHARGE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                HS_IDLE:      state_d = HS_IDLE;
                HS_PRECHARGE: begin
                    if (cnt_q == CNT_W'(CNT_LAST)) state_d = HS_EVALUATE;
                    else                           cnt_d   = cnt_q + 1'b1;
                end
                HS_EVALUATE:  if (layer_done[NUM_LAYERS-1]) state_d = HS_FINISHED;
                HS_FINISHED:  state_d = HS_FINISHED;
                default:      state_d = HS_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        precharge  = 1'b0;
        evaluating = 1'b0;
        net_done   = 1'b0;
        eval_en    = '0;
        unique case (state_q)
            HS_IDLE:      ;
            HS_PRECHARGE: precharge = 1'b1;
            HS_EVALUATE: begin
                evaluating = 1'b1;
                eval_en    = {layer_done[NUM_LAYERS-2:0], 1'b1};
            end
            HS_FINISHED: begin
                net_done = 1'b1;
                eval_en  = {layer_done[NUM_LAYERS-2:0], 1'b1};
            end
            default:      ;
        endcase
    end

    // R2: no evaluation while the neurons are precharging
    a_r2_no_eval_in_precharge : assert property (@(posedge clk) disable iff (!rst_n)
        precharge |-> (eval_en == '0 && layer_done == '0));

    // R8: a strobe always lands in precharge with cleared flags
    a_r8_strobe_restarts : assert property (@(posedge clk) disable iff (!rst_n)
        new_input |=> (precharge && layer_done == '0 && !net_done));

    // R7: network-done holds until a strobe
    a_r7_net_done_hold : assert property (@(posedge clk) disable iff (!rst_n)
        (net_done && !new_input) |=> net_done);

    // R7: network-done only with the final layer flagged
    a_r7_net_done_needs_last : assert property (@(posedge clk) disable iff (!rst_n)
        net_done |-> layer_done[NUM_LAYERS-1]);
endmodule

// File: tb/tb_layer_handshake.sv
module tb_layer_handshake;
    localparam int L   = 3;
    localparam int NPL = 4;
    localparam int PRE = 2;
    localparam int W   = L * NPL;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         new_input = 1'b0;
    logic [W-1:0] ex_out = '0;
    logic [W-1:0] inh_out = '0;
    logic         precharge;
    logic [L-1:0] eval_en;
    logic [L-1:0] layer_done;
    logic         net_done;

    int checks = 0;
    int fails  = 0;

    // bench cycle model: 0 idle, 1 precharge, 2 evaluate, 3 finished
    int           m_st = 0;
    int           m_cnt = 0;
    logic [L-1:0] m_done = '0;

    always #4 clk = ~clk;

    layer_handshake #(
        .NUM_LAYERS(L), .NEURONS_PER_LAYER(NPL), .PRECHARGE_CYCLES(PRE)
    ) dut (
        .clk(clk), .rst_n(rst_n), .new_input(new_input),
        .ex_out(ex_out), .inh_out(inh_out),
        .precharge(precharge), .eval_en(eval_en),
        .layer_done(layer_done), .net_done(net_done)
    );

    function automatic logic [L-1:0] exp_en();
        logic [L-1:0] e;
        e = '0;
        if (m_st >= 2) e = {m_done[L-2:0], 1'b1};
        return e;
    endfunction

    function automatic logic [L-1:0] layers_full(input logic [W-1:0] ex, input logic [W-1:0] ih);
        logic [L-1:0] r;
        logic [W-1:0] f;
        f = ex | ih;
        for (int k = 0; k < L; k++) r[k] = &f[k*NPL +: NPL];
        return r;
    endfunction

    task automatic model_step(input logic ni, input logic [W-1:0] ex, input logic [W-1:0] ih);
        logic [L-1:0] en, full, old;
        en = exp_en(); full = layers_full(ex, ih); old = m_done;
        if (ni) begin
            m_st = 1; m_cnt = 0; m_done = '0;
        end else if (m_st == 1) begin
            if (m_cnt == PRE - 1) m_st = 2; else m_cnt++;
        end else if (m_st == 2) begin
            for (int k = 0; k < L; k++) if (en[k] && full[k]) m_done[k] = 1'b1;
            if (old[L-1]) m_st = 3;
        end
    endtask

    task automatic compare(input string req);
        logic [L+L+1:0] act, exp;
        act = {precharge, eval_en, layer_done, net_done};
        exp = {(m_st == 1), exp_en(), m_done, (m_st == 3)};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {pre,en,done,net} actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic cycle(input logic ni, input logic [W-1:0] ex, input logic [W-1:0] ih, input string req);
        new_input = ni; ex_out = ex; inh_out = ih;
        model_step(ni, ex, ih);
        @(negedge clk);
        compare(req);
    endtask

    function automatic logic [W-1:0] layer_mask(input int k);
        return {{(W-NPL){1'b0}}, {NPL{1'b1}}} << (k * NPL);
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [W-1:0] ex, ih, f;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);
        cycle(0, '1, '0, "R1");        // completions in idle ignored (R5)
        cycle(0, '1, '1, "R5");

        // R2 / R5: strobe, precharge with all neurons already complete
        cycle(1, '1, '0, "R2");
        cycle(0, '1, '0, "R2");
        cycle(0, '1, '1, "R5");
        // evaluate: only layer 1 and 2 complete -> not enabled yet (R5)
        cycle(0, layer_mask(1) | layer_mask(2), '0, "R5");
        cycle(0, layer_mask(1), layer_mask(2), "R5");
        // R3: layer 0 complete through mixed rails
        cycle(0, 12'h005, 12'h00A, "R3");
        cycle(0, layer_mask(1), '0, "R4");
        cycle(0, '0, layer_mask(2), "R4");
        cycle(0, '0, '0, "R7");
        // R6: outputs dropped, flags stay
        repeat (3) cycle(0, '0, '0, "R6");
        repeat (2) cycle(0, '1, '0, "R7");

        // R8: abort mid-round
        cycle(1, '0, '0, "R8");
        cycle(0, '0, '0, "R8");
        cycle(0, '0, '0, "R8");
        cycle(0, layer_mask(0), '0, "R8");
        cycle(0, '0, '0, "R8");
        cycle(1, '1, '1, "R8");
        cycle(0, '1, '1, "R8");
        // strobe during precharge restarts count
        cycle(1, '0, '0, "R8");
        cycle(0, '0, '0, "R2");
        cycle(0, '0, '0, "R2");
        cycle(0, layer_mask(0) & 12'h007, '0, "R3");  // one neuron missing
        cycle(0, '0, '0, "R3");

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic ni;
            ni = ($urandom % 30) == 0;
            ex = '0; ih = '0;
            for (int k = 0; k < L; k++) begin
                if ($urandom % 2) begin
                    for (int j = 0; j < NPL; j++) begin
                        int c;
                        c = $urandom % 3;
                        ex[k*NPL+j] = (c != 1);
                        ih[k*NPL+j] = (c != 0);
                    end
                end else begin
                    f = W'($urandom);
                    ex[k*NPL +: NPL] = f[NPL-1:0];
                    ih[k*NPL +: NPL] = f[2*NPL-1:NPL];
                end
            end
            cycle(ni, ex, ih, "R3");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule